// File: doc/BRIEF.md
# Indirect Window Register Bridge

The bridge lets a register-bus master reach a bank of thirty-two 8-bit control registers through one 32-bit window at bus offset 0x0. One window write carries a bank release flag, a direction flag, a 5-bit index and a byte of write data. The low byte of the window is not storage. It always shows the current contents of the bank entry that the index field selects. A byte enters the bank only when the direction flag goes from 0 to 1 while the bank is released. Software can therefore build up an access one field at a time, and a bus write alone never changes the bank.

A four-state machine follows the two control flags as the window holds them:

- `ST_HELD_RD`: bank held, direction 0.
- `ST_HELD_WR`: bank held, direction 1.
- `ST_IDLE`: released, direction 0.
- `ST_ARMED`: released, direction 1.

Only window writes move the machine. Each window write sends it to the state that matches the new flag values. The move IDLE→ARMED and the move HELD_RD→ARMED are the two commit transitions, and each issues one commit pulse. Every other move commits nothing: HELD_WR→ARMED, ARMED→ARMED, any move into IDLE, and any move into HELD_RD or HELD_WR.

Top module: `indirect_window_bridge`

## Requirements
- R1: On synchronous system reset, all window fields and all 32 bank entries are zero, so a read of offset 0x0 returns 0x00000000 in the first cycle after reset.
- R2: A bus write to offset 0x0 stores the window fields: release at bit 28, direction at bit 24, index at bits 20:16 and write byte at bits 15:8. A read of offset 0x0 returns these fields in the same positions and returns zero in bits 31:29, 27:25 and 23:21.
- R3: Bus writes to bits 7:0 of the window have no effect. Bits 7:0 always read the bank entry selected by the current index.
- R4: A window write that changes the direction bit from 0 to 1 with release at 1 stores the write byte at the indexed entry. A read from the second cycle after that bus write returns the stored byte.
- R5: While the direction bit stays at 1, further window writes commit nothing, even when they change the write byte. Clearing the direction bit to 0 also commits nothing.
- R6: While release is 0, every bank entry is zero and no commit happens. A direction bit that rose while the bank was held does not commit when release later goes to 1.
- R7: After a window write that changes only the index, the next read returns the newly selected entry in bits 7:0.
- R8: Bus writes to any offset other than 0x0 change nothing, and reads from those offsets return zero.
- R9: The commit works both when release, index, data and direction arrive as separate bus writes and when they arrive in a single bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register-bus access |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Some properties are checked by assertions on every cycle:
- at most one commit pulse follows a single window write;
- a commit appears only once the machine has reached ARMED;
- the bank stays zero while it is held;
- the bank does not change when no commit is issued;
- writes to other offsets leave the window fields untouched.

Other behaviour can only be shown by the bench scenarios:
- the values that reach the bank and come back on the read path;
- that a direction bit raised while the bank is held never commits;
- that the low byte follows a change of index.

// File: rtl/iwb_pkg.sv
package iwb_pkg;
    localparam int BUS_DW    = 32;
    localparam int IDX_W     = 5;
    localparam int CELL_W    = 8;
    // field positions decoded by the register bus master
    localparam int REL_BIT   = 28;
    localparam int DIR_BIT   = 24;
    localparam int IDX_LSB   = 16;
    localparam int WBYTE_LSB = 8;

    typedef enum logic [1:0] {
        ST_HELD_RD = 2'd0,
        ST_HELD_WR = 2'd1,
        ST_IDLE    = 2'd2,
        ST_ARMED   = 2'd3
    } iwb_state_e;

    typedef struct packed {
        logic              rel;
        logic              dir;
        logic [IDX_W-1:0]  idx;
        logic [CELL_W-1:0] wbyte;
    } iwb_fields_t;
endpackage

// File: rtl/iwb_window.sv
module iwb_window
    import iwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic              rel_i,
    input  logic              dir_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CELL_W-1:0] wbyte_i,
    output iwb_fields_t       fields_o
);
    iwb_fields_t fields_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (we_i) begin
            fields_q.rel   <= rel_i;
            fields_q.dir   <= dir_i;
            fields_q.idx   <= idx_i;
            fields_q.wbyte <= wbyte_i;
        end
    end

    assign fields_o = fields_q;

    // R2: without a window write the fields must hold
    p_fields_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(fields_q));
endmodule

// File: rtl/iwb_commit_fsm.sv
module iwb_commit_fsm
    import iwb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we_i,
    input  logic rel_i,
    input  logic dir_i,
    output logic commit_o
);
    iwb_state_e state_q, state_d;
    logic       commit_q;

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            unique case ({rel_i, dir_i})
                2'b00: state_d = ST_HELD_RD;
                2'b01: state_d = ST_HELD_WR;
                2'b10: state_d = ST_IDLE;
                2'b11: state_d = ST_ARMED;
                default: state_d = ST_HELD_RD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HELD_RD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_HELD_RD: commit_q <= we_i && (state_d == ST_ARMED);
                ST_HELD_WR, ST_ARMED: commit_q <= 1'b0;
                default: commit_q <= 1'b0;
            endcase
        end
    end

    assign commit_o = commit_q;

    // R4: a commit pulse exists only once ARMED is reached
    p_commit_armed_r4: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> (state_q == ST_ARMED));
    // R5: one window write yields at most one commit
    p_single_commit_r5: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> !commit_q);
    // R4: every commit follows a window write
    p_commit_after_write_r4: assert property (@(posedge clk) disable iff (rst)
        commit_q |-> $past(we_i));
endmodule

// File: rtl/iwb_bank.sv
module iwb_bank
    import iwb_pkg::*;
#(
    parameter int AW = IDX_W,
    parameter int DW = CELL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rel_i,
    input  logic          commit_i,
    input  logic [AW-1:0] idx_i,
    input  logic [DW-1:0] wbyte_i,
    output logic [DW-1:0] rbyte_o
);
    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst || !rel_i)
                cell_q <= '0;
            else if (commit_i && (idx_i == AW'(g)))
                cell_q <= wbyte_i;
        end
        assign cells[g] = cell_q;
    end

    assign rbyte_o = cells[idx_i];

    // R6: a held bank reads all zero on the following cycle
    p_held_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !rel_i |=> (cells == '0));
    // R5: with no commit and release kept, the bank does not move
    p_no_commit_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (!commit_i && rel_i) |=> $stable(cells));
endmodule

// File: rtl/indirect_window_bridge.sv
module indirect_window_bridge
    import iwb_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int WIN_OFFSET = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata
);
    logic              win_hit;
    logic              win_we;
    logic              commit;
    logic [CELL_W-1:0] rbyte;
    iwb_fields_t       fields;

    assign win_hit = (bus_addr == ADDR_W'(WIN_OFFSET));
    assign win_we  = bus_we && win_hit;

    // low byte and spare window bits are discarded on write
    logic ignored_unused;
    assign ignored_unused = ^{bus_wdata[WBYTE_LSB-1:0], bus_wdata[31:29],
                              bus_wdata[27:25], bus_wdata[23:21]};

    iwb_window u_window (
        .clk      (clk),
        .rst      (rst),
        .we_i     (win_we),
        .rel_i    (bus_wdata[REL_BIT]),
        .dir_i    (bus_wdata[DIR_BIT]),
        .idx_i    (bus_wdata[IDX_LSB +: IDX_W]),
        .wbyte_i  (bus_wdata[WBYTE_LSB +: CELL_W]),
        .fields_o (fields)
    );

    iwb_commit_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .we_i     (win_we),
        .rel_i    (bus_wdata[REL_BIT]),
        .dir_i    (bus_wdata[DIR_BIT]),
        .commit_o (commit)
    );

    iwb_bank #(.AW(IDX_W), .DW(CELL_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .rel_i    (fields.rel),
        .commit_i (commit),
        .idx_i    (fields.idx),
        .wbyte_i  (fields.wbyte),
        .rbyte_o  (rbyte)
    );

    always_comb begin
        bus_rdata = '0;
        if (win_hit) begin
            bus_rdata[REL_BIT]                = fields.rel;
            bus_rdata[DIR_BIT]                = fields.dir;
            bus_rdata[IDX_LSB +: IDX_W]       = fields.idx;
            bus_rdata[WBYTE_LSB +: CELL_W]    = fields.wbyte;
            bus_rdata[CELL_W-1:0]             = rbyte;
        end
    end

    // R8: writes elsewhere leave the visible window fields untouched
    p_other_offset_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !win_hit) |=> $stable(fields));
endmodule

// File: tb/indirect_window_bridge_test.sv
module indirect_window_bridge_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    indirect_window_bridge uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one bus write, then one idle cycle so a commit has landed
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_rd(4'h0, v);
        check("R1 reset window", v, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        bus_wr(4'h0, 32'hEEF5_A5FF);
        bus_rd(4'h0, v);
        check("R2 fields and zero spare bits", v, 32'h0015_A500);
        check("R3 low byte ignores bus data", {24'h0, v[7:0]}, 32'h0);
    endtask

    task automatic t_steps();
        logic [31:0] v;
        bus_wr(4'h0, 32'h1000_0000);
        bus_wr(4'h0, 32'h1003_0000);
        bus_wr(4'h0, 32'h1003_5A00);
        bus_rd(4'h0, v);
        check("R4 no commit before direction rise", v, 32'h1003_5A00);
        bus_wr(4'h0, 32'h1103_5A00);
        bus_wr(4'h0, 32'h1003_5A00);
        bus_rd(4'h0, v);
        check("R9 stepwise commit", v, 32'h1003_5A5A);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        bus_wr(4'h0, 32'h1004_1100);
        bus_wr(4'h0, 32'h1104_1100);
        bus_rd(4'h0, v);
        check("R4 commit on rise", v, 32'h1104_1111);
        bus_wr(4'h0, 32'h1104_2200);
        bus_rd(4'h0, v);
        check("R5 held direction no recommit", v, 32'h1104_2211);
        bus_wr(4'h0, 32'h1004_2200);
        bus_rd(4'h0, v);
        check("R5 falling direction no commit", v, 32'h1004_2211);
    endtask

    task automatic t_index();
        logic [31:0] v;
        bus_wr(4'h0, 32'h1003_0000);
        bus_rd(4'h0, v);
        check("R7 index 3 selected", v, 32'h1003_005A);
        bus_wr(4'h0, 32'h1004_0000);
        bus_rd(4'h0, v);
        check("R7 index 4 selected", v, 32'h1004_0011);
    endtask

    task automatic t_other_offset();
        logic [31:0] v;
        bus_wr(4'h4, 32'h1107_7700);
        bus_rd(4'h0, v);
        check("R8 window unchanged", v, 32'h1004_0011);
        bus_rd(4'h4, v);
        check("R8 other offset reads zero", v, 32'h0);
        bus_wr(4'h0, 32'h1007_0000);
        bus_rd(4'h0, v);
        check("R8 entry 7 untouched", v, 32'h1007_0000);
    endtask

    task automatic t_combined();
        logic [31:0] v;
        bus_wr(4'h0, 32'h1109_3C00);
        bus_rd(4'h0, v);
        check("R9 single write commit", v, 32'h1109_3C3C);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        bus_wr(4'h0, 32'h0109_3C00);
        bus_rd(4'h0, v);
        check("R6 held bank zero", v, 32'h0109_3C00);
        bus_wr(4'h0, 32'h1109_3C00);
        bus_rd(4'h0, v);
        check("R6 release with direction high no commit", v, 32'h1109_3C00);
        bus_wr(4'h0, 32'h0009_7700);
        bus_wr(4'h0, 32'h0109_7700);
        bus_wr(4'h0, 32'h1009_7700);
        bus_rd(4'h0, v);
        check("R6 rise while held no commit", v, 32'h1009_7700);
    endtask

    task automatic t_sysreset();
        logic [31:0] v;
        bus_wr(4'h0, 32'h1102_4400);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_rd(4'h0, v);
        check("R1 reset clears window", v, 32'h0);
        bus_wr(4'h0, 32'h1002_0000);
        bus_rd(4'h0, v);
        check("R1 reset clears bank", v, 32'h1002_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fields();
        t_steps();
        t_hold();
        t_index();
        t_other_offset();
        t_combined();
        t_gate();
        t_sysreset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule